// File: doc/BRIEF.md
# PCM-to-PWM Converter with Sample Queue

This block turns a stream of pulse-code samples into a pulse-width-modulated output. A free-running counter sets the period of the output. At the start of each period the block takes one sample from an eight-entry queue. The output stays high while the counter is below that sample. Software or a DMA engine keeps the queue filled. It is prompted by a request line that rises while the number of free slots is above a programmed threshold.

A prescaler sits in front of the period counter. It divides the input clock by 1, 2, 4 or 8. The period length is therefore (period value + 1) times that divisor, counted in input clock cycles. The block also handles the queue running dry or being overfilled:

- If the queue is empty when a period begins, the previous sample is used again and an underrun flag is raised.
- A write to a full queue is dropped and an overflow flag is raised.

The three flags are sticky and are cleared by writing 1. Each flag has its own enable into a single interrupt line.

Top module: `pcm_pwm_conv`

## Requirements
- R1: While enabled, one PWM period lasts (period_cfg + 1) × 2^presc_sel input clock cycles, and exactly one sample is taken from the queue at the start of each period.
- R2: Within a period, pwm_out is high while the counter value is below the current sample and low otherwise. A sample of 0 gives a period that is all low. A sample above period_cfg gives a period that is all high.
- R3: presc_sel is a 2-bit field. A value n makes the counter advance once every 2^n input clock cycles.
- R4: When a period starts and the queue is empty, the previous sample is reused. The underrun flag, status bit 1, is set.
- R5: dreq is high whenever the number of free queue slots is strictly greater than free_thr. While dreq is high, status bit 0 is set.
- R6: A write while the queue holds 8 samples is dropped. The overflow flag, status bit 2, is set.
- R7: Status bits stay set until a 1 is written to the matching bit of clr_stat. If a set condition and a clear happen in the same cycle, the set wins.
- R8: irq is the OR over all bits of status AND irq_en.
- R9: While enable is low, pwm_out is low. Raising enable restarts the counter at 0 and loads the first sample from the queue.
- R10: Changes to period_cfg and presc_sel take effect only at the next period boundary. The period in progress is never cut short.
- R11: Samples are consumed in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; the rising edge restarts the period |
| period_cfg | input | CNT_W | Last counter value of a period |
| presc_sel | input | 2 | Prescaler select, division by 2^value |
| free_thr | input | LW | Free-slot threshold for the data request |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | SMP_W | Sample to enqueue |
| clr_stat | input | 3 | Write-1-to-clear for the status bits |
| irq_en | input | 3 | Per-bit interrupt enables |
| pwm_out | output | 1 | Modulated output |
| dreq | output | 1 | Data request level, for an interrupt or DMA |
| status | output | 3 | Sticky flags: bit0 request, bit1 underrun, bit2 overflow |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, 16-bit samples and an eight-deep queue. Because the period is a run-time field, the bench can program periods of 4 to 16 counts. Each period can then be measured cycle by cycle, including mid-period reconfiguration and restarts. An eight-entry queue fills within nine writes, so overflow, in-order draining and the underrun repeat after the last sample all fall inside one short sequence. A 4-bit threshold lets every free-count comparison around the request edge be reached.

// File: rtl/pcm_pwm_conv.sv
module pcm_pwm_conv #(
  parameter int CNT_W = 16,
  parameter int SMP_W = 16,
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [1:0]       presc_sel,
  input  logic [LW-1:0]    free_thr,
  input  logic             wr_en,
  input  logic [SMP_W-1:0] wr_data,
  input  logic [2:0]       clr_stat,
  input  logic [2:0]       irq_en,
  output logic             pwm_out,
  output logic             dreq,
  output logic [2:0]       status,
  output logic             irq
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int W  = (CNT_W > SMP_W) ? CNT_W : SMP_W;

  logic [SMP_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    fill;
  logic             full, empty, push, pop, pop_req;

  logic             run, start, tick, wrap;
  logic [CNT_W-1:0] cnt, act_period;
  logic [1:0]       act_sel;
  logic [2:0]       div, div_lim;
  logic [SMP_W-1:0] cur;

  assign full  = (fill == LW'(DEPTH));
  assign empty = (fill == '0);
  assign push  = wr_en && !full;
  assign start = enable && !run;
  assign wrap  = run && enable && tick && (cnt == act_period);
  assign pop_req = start || wrap;
  assign pop   = pop_req && !empty;

  always_comb begin
    case (act_sel)
      2'd0: div_lim = 3'd0;
      2'd1: div_lim = 3'd1;
      2'd2: div_lim = 3'd3;
      default: div_lim = 3'd7;
    endcase
  end
  assign tick = (div == div_lim);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      cnt        <= '0;
      div        <= '0;
      act_period <= '0;
      act_sel    <= '0;
      cur        <= '0;
    end else if (!enable) begin
      run <= 1'b0;
      cnt <= '0;
      div <= '0;
    end else if (start) begin
      run        <= 1'b1;
      cnt        <= '0;
      div        <= '0;
      act_period <= period_cfg;
      act_sel    <= presc_sel;
      if (!empty) cur <= mem[rd_ptr];
    end else if (tick) begin
      div <= '0;
      if (cnt == act_period) begin
        cnt        <= '0;
        act_period <= period_cfg;
        act_sel    <= presc_sel;
        if (!empty) cur <= mem[rd_ptr];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      div <= div + 1'b1;
    end
  end

  assign pwm_out = run && (W'(cnt) < W'(cur));

  logic [LW-1:0] free_slots;
  assign free_slots = LW'(DEPTH) - fill;
  assign dreq = (free_slots > free_thr);

  logic [2:0] set_v;
  assign set_v = {wr_en && full, pop_req && empty, dreq};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_stat) | set_v;
  end

  assign irq = |(status & irq_en);

endmodule

// File: rtl/pcm_pwm_conv_chk.sv
module pcm_pwm_conv_chk #(
  parameter int DEPTH = 8,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          wr_en,
  input logic          pop_req,
  input logic [LW-1:0] fill,
  input logic          pwm_out,
  input logic          dreq,
  input logic [2:0]    status,
  input logic [2:0]    clr_stat
);

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pwm_out); // R9

  AST_UDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !clr_stat[1]) |=> status[1]); // R7

  AST_REQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |=> status[0]); // R5

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill == LW'(DEPTH)) |=> status[2]); // R6

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pop_req && fill == LW'(DEPTH)) |=> $stable(fill)); // R6

  AST_UDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && fill == '0) |=> status[1]); // R4

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= LW'(DEPTH)); // R11

endmodule

bind pcm_pwm_conv pcm_pwm_conv_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
  .pop_req(pop_req), .fill(fill), .pwm_out(pwm_out), .dreq(dreq),
  .status(status), .clr_stat(clr_stat)
);

// File: tb/pcm_pwm_conv_bench.sv
module pcm_pwm_conv_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] period_cfg = 16'd9;
  logic [1:0]  presc_sel = 2'd0;
  logic [3:0]  free_thr = 4'd3;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  clr_stat = '0;
  logic [2:0]  irq_en = '0;
  logic        pwm_out, dreq, irq;
  logic [2:0]  status;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pcm_pwm_conv u_pcm_pwm_conv (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_cfg(period_cfg),
    .presc_sel(presc_sel), .free_thr(free_thr), .wr_en(wr_en), .wr_data(wr_data),
    .clr_stat(clr_stat), .irq_en(irq_en), .pwm_out(pwm_out), .dreq(dreq),
    .status(status), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] p;
    logic [1:0]  sel;
    logic [15:0] s;
    logic [15:0] hi;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{16'd9,  2'd0, 16'd4,  16'd4},
    '{16'd9,  2'd0, 16'd0,  16'd0},
    '{16'd9,  2'd0, 16'd12, 16'd10},
    '{16'd9,  2'd0, 16'd10, 16'd10},
    '{16'd9,  2'd1, 16'd3,  16'd6},
    '{16'd7,  2'd2, 16'd5,  16'd20},
    '{16'd3,  2'd3, 16'd2,  16'd16},
    '{16'd15, 2'd0, 16'd15, 16'd15},
    '{16'd4,  2'd0, 16'd5,  16'd5}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int v);
    wr_en = 1'b1;
    wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int len, output int highs);
    highs = 0;
    repeat (len) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
  endtask

  task automatic stop_clear();
    enable = 1'b0;
    repeat (2) @(negedge clk);
    clr_stat = 3'b111;
    @(negedge clk);
    clr_stat = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int h;
    int h2;
    int len;
    int ord [9];
    logic seq [17];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset pwm", pwm_out, 0);
    check("R4 reset underrun", status[1], 0);
    check("R6 reset overflow", status[2], 0);
    check("R5 reset dreq", dreq, 1);

    for (int i = 0; i < 9; i++) begin
      stop_clear();
      period_cfg = VEC[i].p;
      presc_sel = VEC[i].sel;
      push(VEC[i].s);
      enable = 1'b1;
      @(negedge clk);
      len = (int'(VEC[i].p) + 1) << VEC[i].sel;
      measure(len, h);
      check(VEC[i].sel != 0 ? "R3 prescaled duty" : "R2 duty", h, int'(VEC[i].hi));
      measure(len, h2);
      check("R4 repeat on empty", h2, int'(VEC[i].hi));
      check("R4 underrun flag", status[1], 1);
    end

    stop_clear();
    period_cfg = 16'd3;
    presc_sel = 2'd0;
    free_thr = 4'd3;
    for (int i = 0; i < 9; i++) begin
      ord[i] = (i * 3) % 5;
      push(ord[i]);
    end
    check("R6 overflow flag", status[2], 1);
    check("R5 dreq low when full", dreq, 0);
    enable = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      measure(4, h);
      check("R11 order", h, ord[i]);
    end
    measure(4, h);
    check("R6 dropped write", h, ord[7]);

    stop_clear();
    check("R5 dreq empty", dreq, 1);
    clr_stat = 3'b001;
    @(negedge clk);
    clr_stat = '0;
    check("R7 set wins over clear", status[0], 1);
    for (int i = 0; i < 4; i++) push(1);
    check("R5 free 4 above 3", dreq, 1);
    push(1);
    check("R5 free 3 not above 3", dreq, 0);
    clr_stat = 3'b001;
    @(negedge clk);
    clr_stat = '0;
    check("R7 clear request flag", status[0], 0);
    period_cfg = 16'd0;
    enable = 1'b1;
    repeat (8) @(negedge clk);

    stop_clear();
    irq_en = 3'b000;
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R8 masked", irq, 0);
    irq_en = 3'b010;
    #1;
    check("R8 underrun enabled", irq, 1);
    clr_stat = 3'b010;
    @(negedge clk);
    clr_stat = '0;
    check("R7 clear underrun", status[1], 0);
    check("R8 after clear", irq, 0);
    irq_en = 3'b001;
    #1;
    check("R8 request enabled", irq, 1);
    irq_en = '0;

    stop_clear();
    period_cfg = 16'd9;
    push(3);
    push(2);
    push(1);
    enable = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 17; c++) begin
      if (c == 2) period_cfg = 16'd4;
      seq[c] = pwm_out;
      @(negedge clk);
    end
    for (int c = 0; c < 17; c++) begin
      int e;
      e = (c < 10) ? int'(c < 3) : (c < 15) ? int'((c - 10) < 2) : int'((c - 15) < 1);
      check(c < 10 ? "R10 period kept" : "R1 new period", int'(seq[c]), e);
    end

    stop_clear();
    period_cfg = 16'd9;
    push(5);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 low when off", pwm_out, 0);
    push(7);
    enable = 1'b1;
    @(negedge clk);
    measure(10, h);
    check("R9 restart load", h, 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule